// File: doc/BRIEF.md
# Sensor row zero-bias preprocessor

This block takes a raw frame from an image sensor's parallel pixel output and removes the dark-level offset row by row. The sensor delivers each of the 64 rows as 66 consecutive bytes. The first 64 bytes are image pixels. The last two come from light-shielded reference columns. The block averages the two reference samples of a row and subtracts that average from the 64 image pixels of the same row. It keeps the corrected 64x64 frame in an internal buffer.

A host pulses a start command while the block is idle. It then feeds pixels through a valid/ready handshake and waits for the done pulse or for the busy status to drop. After that it pops the corrected frame one pixel per request, in row-major order. The sequencing is a five-phase controller: idle, row load, bias compute, bias fix and row advance.

Top module: `zb_rowfix`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `pix_ready_o`, `done_o` and `pop_valid_o` are 0.
- R2: A `start_i` pulse while idle makes `busy_o` and `pix_ready_o` read 1 from the next cycle on. `busy_o` stays 1 until the whole frame is corrected.
- R3: Each row accepts exactly 66 pixels, one per cycle in which `pix_valid_i` and `pix_ready_o` are both 1. Pixels 0 to 63 are image data and pixels 64 and 65 are the reference samples. After the 66th pixel, `pix_ready_o` stays 0 for 66 cycles before the next row opens.
- R4: The bias of a row is the sum of its two reference samples divided by 2, rounded down. Both samples are read as unsigned 8-bit values.
- R5: Each stored pixel equals (raw pixel − row bias) modulo 256: an 8-bit two's-complement result that wraps without saturation.
- R6: After the 64th row, `busy_o` falls and `done_o` is 1 for exactly one cycle, in the first idle cycle.
- R7: A `start_i` pulse while busy is ignored. Row sequencing, timing and stored data are unchanged.
- R8: While idle, a `pop_i` cycle gives `pop_valid_o` = 1 one cycle later, with the next corrected pixel in row-major order (index row*64+column) on `pop_data_o`. While busy, `pop_i` is ignored and `pop_valid_o` stays 0.
- R9: `pop_last_o` is 1 together with the pixel at index 4095. The next pop returns index 0 again.
- R10: Cycles with `pix_valid_i` = 0 during a row load stall the load without losing or repeating a pixel.
- R11: An accepted start resets the pop position, so the first pop after a new frame returns index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame (honoured only while idle) |
| pix_valid_i | input | 1 | Sensor pixel present |
| pix_data_i | input | 8 | Sensor pixel value |
| pix_ready_o | output | 1 | Block accepts a pixel this cycle |
| busy_o | output | 1 | Frame capture or correction in progress |
| done_o | output | 1 | One-cycle pulse when the frame is complete |
| pop_i | input | 1 | Request the next corrected pixel |
| pop_valid_o | output | 1 | `pop_data_o` holds a popped pixel |
| pop_data_o | output | 8 | Corrected pixel |
| pop_last_o | output | 1 | Popped pixel is the last one of the frame |

## Verification
`busy_o` and `pix_ready_o` change one cycle after an accepted start. The ready gap begins on the cycle after a row's 66th pixel and ends after 66 further clock edges. `done_o` appears in the first idle cycle after the last row's advance. Popped data arrives one cycle after the request. The bench keeps a behavioural model that is updated at each rising edge from the inputs it drove. It compares all outputs against that model at each falling edge, so every result is checked in exactly the cycle it is due. The stimulus includes input stalls, start and pop requests issued mid-frame, reference pairs that make the bias exceed the pixel values, and a pop across the end of the frame.

// File: rtl/zb_pkg.sv
package zb_pkg;

  typedef enum logic [2:0] {
    ZB_IDLE,
    ZB_LOAD,
    ZB_BIAS,
    ZB_FIX,
    ZB_ADV
  } zb_state_e;

endpackage

// File: rtl/zb_ctrl.sv
module zb_ctrl
  import zb_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int REFS = 2,
  localparam int SPAN = COLS + REFS,
  localparam int CW = $clog2(SPAN),
  localparam int RW = $clog2(ROWS),
  localparam int AW = $clog2(ROWS * COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          pix_valid_i,
  output logic          busy_o,
  output logic          ready_o,
  output logic          done_o,
  output logic          wr_en_o,
  output logic          wr_fix_o,
  output logic          ref_en_o,
  output logic          calc_o,
  output logic [CW-1:0] col_o,
  output logic [AW-1:0] addr_o
);

  zb_state_e     state_q, state_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    col_d   = col_q;
    unique case (state_q)
      ZB_IDLE: begin
        row_d = '0;
        col_d = '0;
        if (start_i) state_d = ZB_LOAD;
      end
      ZB_LOAD: begin
        if (pix_valid_i) begin
          if (col_q == CW'(SPAN - 1)) begin
            col_d   = '0;
            state_d = ZB_BIAS;
          end else begin
            col_d = col_q + 1'b1;
          end
        end
      end
      ZB_BIAS: begin
        col_d   = '0;
        state_d = ZB_FIX;
      end
      ZB_FIX: begin
        if (col_q == CW'(COLS - 1)) begin
          col_d   = '0;
          state_d = ZB_ADV;
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      ZB_ADV: begin
        if (row_q == RW'(ROWS - 1)) begin
          row_d   = '0;
          state_d = ZB_IDLE;
        end else begin
          row_d   = row_q + 1'b1;
          state_d = ZB_LOAD;
        end
      end
      default: state_d = ZB_IDLE;
    endcase
  end

  assign done_d = (state_q == ZB_ADV) && (row_q == RW'(ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ZB_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
      done_q  <= done_d;
    end
  end

  assign busy_o   = (state_q != ZB_IDLE);
  assign ready_o  = (state_q == ZB_LOAD);
  assign done_o   = done_q;
  assign calc_o   = (state_q == ZB_BIAS);
  assign wr_fix_o = (state_q == ZB_FIX);
  assign wr_en_o  = wr_fix_o || (ready_o && pix_valid_i && (col_q < CW'(COLS)));
  assign ref_en_o = ready_o && pix_valid_i && (col_q >= CW'(COLS));
  assign col_o    = col_q;
  assign addr_o   = AW'(row_q) * AW'(COLS) + AW'(col_q);

  // R3: the column index never leaves the 66-byte row span
  a_r3_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col_q < CW'(SPAN));

  // R3: the bias phase is entered only right after the last reference byte
  a_r3_bias_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ZB_BIAS) |-> ($past(pix_valid_i) && ($past(col_q) == CW'(SPAN - 1))));

  // R7: inside a row the row index cannot be disturbed by any input
  a_r7_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ZB_IDLE && state_q != ZB_ADV) |=> (row_q == $past(row_q)));

  // R6: completion is a single-cycle pulse seen while idle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((state_q == ZB_IDLE) && $past(state_q == ZB_ADV)));

endmodule

// File: rtl/zb_bias.sv
module zb_bias #(
  parameter int W = 8,
  parameter int COLS = 64,
  parameter int REFS = 2,
  localparam int CW = $clog2(COLS + REFS),
  localparam int SW = W + $clog2(REFS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en_i,
  input  logic [CW-1:0] col_i,
  input  logic [W-1:0]  pix_i,
  input  logic          calc_i,
  input  logic [W-1:0]  old_i,
  output logic [W-1:0]  fixed_o
);

  logic [W-1:0]  ref_vals [REFS];
  logic [SW-1:0] sum;
  logic [W-1:0]  bias_q, bias_d;

  for (genvar g = 0; g < REFS; g++) begin : g_ref
    logic [W-1:0] ref_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q <= '0;
      end else if (ref_en_i && (col_i == CW'(COLS + g))) begin
        ref_q <= pix_i;
      end
    end
    assign ref_vals[g] = ref_q;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < REFS; i++) sum = sum + SW'(ref_vals[i]);
  end

  assign bias_d = W'(sum / SW'(REFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_q <= '0;
    end else if (calc_i) begin
      bias_q <= bias_d;
    end
  end

  assign fixed_o = old_i - bias_q;

  // R4: the row bias changes only in the compute phase
  a_r4_bias_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_i |=> $stable(bias_q));

endmodule

// File: rtl/zb_store.sv
module zb_store #(
  parameter int W = 8,
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  rad_o,
  output logic [W-1:0]  rbd_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  assign rad_o = mem[wa_i];
  assign rbd_o = mem[rb_i];

endmodule

// File: rtl/zb_pop.sv
module zb_pop #(
  parameter int W = 8,
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_i,
  input  logic          pop_i,
  input  logic          clear_i,
  input  logic [W-1:0]  rd_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic [W-1:0]  data_o,
  output logic          last_o
);

  logic [AW-1:0] ptr_q;
  logic          take, at_end;
  logic          valid_q, last_q;
  logic [W-1:0]  data_q;

  assign take   = pop_i && idle_i;
  assign at_end = (ptr_q == AW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      valid_q <= take;
      if (clear_i) begin
        ptr_q <= '0;
      end else if (take) begin
        ptr_q  <= at_end ? '0 : ptr_q + 1'b1;
      end
      if (take) last_q <= at_end;
    end
  end

  always_ff @(posedge clk) begin
    if (take) data_q <= rd_i;
  end

  assign addr_o  = ptr_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = valid_q && last_q;

  // R8: a popped pixel only follows a request made while idle
  a_r8_pop_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(pop_i && idle_i));

  // R9: the end flag never appears without a pixel
  a_r9_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

endmodule

// File: rtl/zb_rowfix.sv
module zb_rowfix #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int REFS  = 2,
  localparam int DEPTH = ROWS * COLS,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(COLS + REFS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             pix_ready_o,
  output logic             busy_o,
  output logic             done_o,
  input  logic             pop_i,
  output logic             pop_valid_o,
  output logic [PIX_W-1:0] pop_data_o,
  output logic             pop_last_o
);

  logic             wr_en, wr_fix, ref_en, calc;
  logic [CW-1:0]    col;
  logic [AW-1:0]    addr, pop_addr;
  logic [PIX_W-1:0] old_pix, fixed_pix, wr_data, pop_rd;

  zb_ctrl #(.ROWS(ROWS), .COLS(COLS), .REFS(REFS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pix_valid_i (pix_valid_i),
    .busy_o      (busy_o),
    .ready_o     (pix_ready_o),
    .done_o      (done_o),
    .wr_en_o     (wr_en),
    .wr_fix_o    (wr_fix),
    .ref_en_o    (ref_en),
    .calc_o      (calc),
    .col_o       (col),
    .addr_o      (addr)
  );

  zb_bias #(.W(PIX_W), .COLS(COLS), .REFS(REFS)) u_bias (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en_i (ref_en),
    .col_i    (col),
    .pix_i    (pix_data_i),
    .calc_i   (calc),
    .old_i    (old_pix),
    .fixed_o  (fixed_pix)
  );

  assign wr_data = wr_fix ? fixed_pix : pix_data_i;

  zb_store #(.W(PIX_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we_i  (wr_en),
    .wa_i  (addr),
    .wd_i  (wr_data),
    .rb_i  (pop_addr),
    .rad_o (old_pix),
    .rbd_o (pop_rd)
  );

  zb_pop #(.W(PIX_W), .DEPTH(DEPTH)) u_pop (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle_i  (!busy_o),
    .pop_i   (pop_i),
    .clear_i (start_i && !busy_o),
    .rd_i    (pop_rd),
    .addr_o  (pop_addr),
    .valid_o (pop_valid_o),
    .data_o  (pop_data_o),
    .last_o  (pop_last_o)
  );

  // R2: pixels are only accepted inside a running frame
  a_r2_ready_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready_o |-> busy_o);

  // R6: done follows the end of a busy period
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/test_zb_rowfix.sv
module test_zb_rowfix;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, pix_valid_i, pop_i;
  logic [7:0] pix_data_i;
  logic       pix_ready_o, busy_o, done_o;
  logic       pop_valid_o, pop_last_o;
  logic [7:0] pop_data_o;

  always #2 clk = ~clk;

  zb_rowfix i_zb_rowfix (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .pix_ready_o (pix_ready_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pop_i       (pop_i),
    .pop_valid_o (pop_valid_o),
    .pop_data_o  (pop_data_o),
    .pop_last_o  (pop_last_o)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string ph_tag = "R5";

  // behavioural reference
  int m_busy, m_ready, m_done, m_pv, m_pdata, m_plast, m_pptr;
  int m_row, m_col, m_gap;
  int raw [66];
  int expv [4096];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int pixf(int img, int r, int c);
    if (c < 64) return (r * 37 + c * 11 + img * 91 + (r * c) % 7) & 255;
    case (r)
      0: return 255;
      1: return (c == 64) ? 255 : 254;
      2: return (c == 64) ? 0 : 1;
      3: return 0;
      default: return (c == 64) ? ((r * 53 + img * 17) & 255) : ((r * 29 + img * 61 + 3) & 255);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 0; m_done = 0; m_pv = 0; m_pptr = 0;
      m_row = 0; m_col = 0; m_gap = 0; m_pdata = 0; m_plast = 0;
    end else begin
      m_pv = 0;
      if (m_busy == 0) begin
        m_done = 0;
        if (pop_i) begin
          m_pv = 1;
          m_pdata = expv[m_pptr];
          m_plast = (m_pptr == 4095);
          m_pptr = (m_pptr + 1) % 4096;
        end
        if (start_i) begin  // R11: new frame restarts the pop position
          m_busy = 1; m_ready = 1; m_row = 0; m_col = 0; m_pptr = 0;
        end
      end else if (m_ready != 0) begin
        if (pix_valid_i) begin  // R10: stalls consume nothing
          raw[m_col] = int'(pix_data_i);
          m_col++;
          if (m_col == 66) begin
            int b;
            b = (raw[64] + raw[65]) / 2;  // R4
            for (int c = 0; c < 64; c++) expv[m_row * 64 + c] = (raw[c] - b) & 255;  // R5
            m_ready = 0;
            m_gap = 66;
          end
        end
      end else begin
        m_gap--;
        if (m_gap == 0) begin
          if (m_row == 63) begin
            m_busy = 0; m_done = 1;
          end else begin
            m_row++; m_col = 0; m_ready = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy_o == m_busy[0], "R2 R6 busy", busy_o, m_busy);
      chk(pix_ready_o == m_ready[0], "R3 R10 ready", pix_ready_o, m_ready);
      chk(done_o == m_done[0], "R6 done", done_o, m_done);
      chk(pop_valid_o == m_pv[0], "R8 pop_valid", pop_valid_o, m_pv);
      if (m_pv != 0) begin
        chk(int'(pop_data_o) == m_pdata, ph_tag, pop_data_o, m_pdata);
        chk(pop_last_o == m_plast[0], "R9 last", pop_last_o, m_plast);
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_image(input int img, input bit gaps, input bit noise);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 100000; k++) begin
      if (m_busy == 0) break;
      pix_valid_i = gaps ? (((k * 7) % 5) != 0) : 1'b1;
      pix_data_i  = (m_col < 66) ? 8'(pixf(img, m_row, m_col)) : 8'h00;
      start_i     = noise && ((k % 97) == 5);  // R7: ignored mid-frame
      pop_i       = noise && ((k % 89) == 3);  // R8: ignored mid-frame
      @(negedge clk);
    end
    pix_valid_i = 1'b0;
    start_i = 1'b0;
    pop_i = 1'b0;
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      pop_i = 1'b1;
      @(negedge clk);
    end
    pop_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    pix_valid_i = 1'b0;
    pix_data_i = 8'h00;
    pop_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(pix_ready_o == 1'b0, "R1 ready", pix_ready_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(pop_valid_o == 1'b0, "R1 pop_valid", pop_valid_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy after release", busy_o, 0);

    // plain frame, includes rows whose bias exceeds the pixels
    run_image(0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    ph_tag = "R4 R5 R8 data";
    pop_n(4096);
    ph_tag = "R9 wrap data";
    pop_n(1);
    pop_n(9);

    // stalled frame with stray start and pop requests
    run_image(1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    ph_tag = "R7 R10 R11 data";
    pop_n(4096);
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule